// File: doc/BRIEF.md
# Strobe-Multiplexed One-Bit DRAM Model

This block is a synthesizable model of a small dynamic memory as seen from its pins. A single shared address bus carries first a row number and then a column number. Active-low row and column strobes mark which phase is on the bus, and an active-low write strobe picks between reading and writing. Data moves one bit at a time. The store holds 64 rows of 64 one-bit cells.

The strobes are level signals from another timing domain. Each one passes through a two-stage synchronizer and an edge detector that run on a fast system clock. Every state change happens on a detected edge. When the row strobe falls, the addressed row is copied into a row buffer. Column accesses read or modify bits in that buffer. When the row strobe rises, the buffer is written back to the array.

While a row is open, extra column strobes give page-mode access. A nibble option makes each later column strobe step through an aligned group of four columns. If the column strobe is already low when the row strobe falls, the cycle is a refresh of the row held in an internal pointer. The pointer is visible on an output so that a controller or a bench can follow the sweep.

Top module: `strobe_dram`

## Requirements
- R1: After reset, `q_en` is 0, `q` is 0, `rfsh_row` is 0 and every cell of the array reads 0.
- R2: A falling edge on `ras_n` while `cas_n` is high opens the row given by `addr[ROW_W-1:0]`. Later column accesses reach only that row's cells.
- R3: A falling edge on `cas_n` with `we_n` high, in an open row, takes the column from `addr[COL_W-1:0]`. It then drives the stored bit on `q` with `q_en` at 1.
- R4: A falling edge on `cas_n` with `we_n` low replaces the addressed bit with `d`. When `ras_n` rises, the row is stored back, so the new value appears in later row cycles.
- R5: `q_en` is 1 only in the span from a read's detected `cas_n` fall to the detected `cas_n` rise. It stays 0 during write accesses, during refresh and while no row is open. `q` is 0 whenever `q_en` is 0.
- R6: Several `cas_n` pulses within one low period of `ras_n` each use a new column of the same row. A bit written earlier in that period reads back its new value.
- R7: With `nib_mode` at 1, the first column strobe of a row cycle takes its column from `addr`. Each later strobe ignores `addr`: it adds 1 modulo 4 to the two low column bits and keeps the upper column bits.
- R8: If `cas_n` is low when `ras_n` falls, the cycle is a refresh. Row `rfsh_row` is rewritten with its own contents. `rfsh_row` then advances by 1 when `ras_n` rises, and it wraps from 63 to 0. No data is driven during a refresh.
- R9: A read's `q_en` and `q` are valid no later than 4 system clock cycles after `cas_n` falls. `addr`, `we_n` and `d` must stay stable over that span.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 6 | Shared row/column address bus |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write select, active low, sampled at the column strobe fall |
| d | input | 1 | Write data bit |
| nib_mode | input | 1 | 1: later column strobes step through a four-column group |
| q | output | 1 | Read data bit, 0 when not driven |
| q_en | output | 1 | Output enable; 1 stands for a driven (not high-impedance) output |
| rfsh_row | output | 6 | Row the next refresh cycle will rewrite |

## Verification
The bench builds the block with its default 6-bit row and column widths. These give the full 64-row refresh sweep, so the pointer wrap from 63 to 0 is reached with about 1,500 cycles of refresh traffic. Rows written before the sweep are read back afterwards to show that refresh keeps their data. Nibble reads start in the middle of an aligned four-column group and carry on past its end. This exposes both a missing wrap and any dependence on the address bus.

// File: rtl/strobe_dram_pkg.sv
package strobe_dram_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_OPEN = 2'd1,
        PH_RFSH = 2'd2
    } phase_e;

    localparam int STB_RAS = 0;
    localparam int STB_CAS = 1;
    localparam int STB_NUM = 2;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_n,
    output logic [N-1:0] lvl,
    output logic [N-1:0] fall,
    output logic [N-1:0] rise
);
    for (genvar i = 0; i < N; i++) begin : g_stb
        logic s1_q, s2_q, prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q   <= 1'b1;
                s2_q   <= 1'b1;
                prev_q <= 1'b1;
            end else begin
                s1_q   <= pin_n[i];
                s2_q   <= s1_q;
                prev_q <= s2_q;
            end
        end
        assign lvl[i]  = s2_q;
        assign fall[i] = prev_q & ~s2_q;
        assign rise[i] = ~prev_q & s2_q;
    end
endmodule

// File: rtl/row_array.sv
module row_array #(
    parameter int ROW_W = 6,
    parameter int COLS  = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] rd_row,
    output logic [COLS-1:0]  rd_data,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [COLS-1:0]  wr_data
);
    localparam int ROWS = 1 << ROW_W;

    logic [COLS-1:0] cells_q [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cells_q[r] <= '0;
            else if (wr_en && wr_row == ROW_W'(r))
                cells_q[r] <= wr_data;
        end
    end

    assign rd_data = cells_q[rd_row];
endmodule

// File: rtl/strobe_dram.sv
module strobe_dram
    import strobe_dram_pkg::*;
#(
    parameter int ROW_W = 6,
    parameter int COL_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [(ROW_W > COL_W ? ROW_W : COL_W)-1:0] addr,
    input  logic                ras_n,
    input  logic                cas_n,
    input  logic                we_n,
    input  logic                d,
    input  logic                nib_mode,
    output logic                q,
    output logic                q_en,
    output logic [ROW_W-1:0]    rfsh_row
);
    localparam int COLS  = 1 << COL_W;
    localparam int NIB_W = 2;
    localparam logic [ROW_W-1:0] ROW_ONE = ROW_W'(1);
    localparam logic [NIB_W-1:0] NIB_ONE = NIB_W'(1);

    typedef struct packed {
        phase_e           ph;
        logic [ROW_W-1:0] row;
        logic [COLS-1:0]  rbuf;
        logic [COL_W-1:0] col;
        logic             seen;
        logic             dq;
        logic             oe;
        logic [ROW_W-1:0] ptr;
    } state_t;

    state_t s_q, s_d;

    logic [STB_NUM-1:0] sy_lvl, sy_fall, sy_rise;
    logic [ROW_W-1:0]   rd_row, wr_row;
    logic [COLS-1:0]    rd_data;
    logic               wr_en;
    logic [COL_W-1:0]   col_sel;

    strobe_sync #(.N(STB_NUM)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n ({cas_n, ras_n}),
        .lvl   (sy_lvl),
        .fall  (sy_fall),
        .rise  (sy_rise)
    );

    row_array #(.ROW_W(ROW_W), .COLS(COLS)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_row  (rd_row),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_row  (wr_row),
        .wr_data (s_q.rbuf)
    );

    // a low column level at the row strobe fall selects the refresh row
    assign rd_row = sy_lvl[STB_CAS] ? addr[ROW_W-1:0] : s_q.ptr;

    // column for this strobe: bus address, or next in the aligned group of four
    always_comb begin
        if (nib_mode && s_q.seen)
            col_sel = {s_q.col[COL_W-1:NIB_W], s_q.col[NIB_W-1:0] + NIB_ONE};
        else
            col_sel = addr[COL_W-1:0];
    end

    always_comb begin
        s_d    = s_q;
        wr_en  = 1'b0;
        wr_row = s_q.row;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (sy_fall[STB_RAS]) begin
                    s_d.rbuf = rd_data;
                    s_d.seen = 1'b0;
                    if (sy_lvl[STB_CAS]) begin
                        s_d.ph  = PH_OPEN;
                        s_d.row = addr[ROW_W-1:0];
                    end else begin
                        s_d.ph  = PH_RFSH;
                    end
                end
            end
            PH_OPEN: begin
                if (sy_rise[STB_RAS]) begin
                    wr_en    = 1'b1;
                    s_d.ph   = PH_IDLE;
                    s_d.oe   = 1'b0;
                    s_d.dq   = 1'b0;
                end else begin
                    if (sy_fall[STB_CAS]) begin
                        s_d.col  = col_sel;
                        s_d.seen = 1'b1;
                        if (!we_n) begin
                            s_d.rbuf[col_sel] = d;
                        end else begin
                            s_d.dq = s_q.rbuf[col_sel];
                            s_d.oe = 1'b1;
                        end
                    end
                    if (sy_rise[STB_CAS]) begin
                        s_d.oe = 1'b0;
                        s_d.dq = 1'b0;
                    end
                end
            end
            PH_RFSH: begin
                if (sy_rise[STB_RAS]) begin
                    wr_en  = 1'b1;
                    wr_row = s_q.ptr;
                    s_d.ptr = s_q.ptr + ROW_ONE;
                    s_d.ph  = PH_IDLE;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.ph <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign q        = s_q.oe ? s_q.dq : 1'b0;
    assign q_en     = s_q.oe;
    assign rfsh_row = s_q.ptr;

    // R2: outside the closing cycle, an active phase implies the row strobe is low
    p_ras_low_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph != PH_IDLE && !sy_rise[STB_RAS]) |-> !sy_lvl[STB_RAS]);

    // R5: enable drops after a column strobe rise
    p_oe_off_after_cas_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sy_rise[STB_CAS] |=> !q_en);

    // R5: no drive unless a row is open
    p_oe_only_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph != PH_OPEN) |-> !q_en);

    // R6: the open row stays fixed through page accesses
    p_row_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_OPEN) |=> $stable(s_q.row));

    // R7: nibble stepping keeps the upper column bits
    p_nibble_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_OPEN && sy_fall[STB_CAS] && !sy_rise[STB_RAS] && nib_mode && s_q.seen)
        |=> s_q.col[COL_W-1:NIB_W] == $past(s_q.col[COL_W-1:NIB_W]));

    // R8: pointer advances by one at the end of a refresh
    p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_RFSH && sy_rise[STB_RAS]) |=> rfsh_row == $past(rfsh_row) + ROW_ONE);

    // R8: pointer is unchanged otherwise
    p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.ph == PH_RFSH && sy_rise[STB_RAS]) |=> $stable(rfsh_row));
endmodule

// File: tb/tb_strobe_dram.sv
module tb_strobe_dram;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] addr;
    logic       ras_n, cas_n, we_n, d, nib_mode;
    logic       q, q_en;
    logic [5:0] rfsh_row;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    strobe_dram dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .d(d), .nib_mode(nib_mode), .q(q), .q_en(q_en),
        .rfsh_row(rfsh_row)
    );

    task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic ras_dn(input logic [5:0] r);
        addr = r; ras_n = 1'b0; settle();
    endtask

    task automatic ras_up();
        ras_n = 1'b1; settle();
    endtask

    task automatic cas_up();
        cas_n = 1'b1; settle();
    endtask

    task automatic cas_wr(input logic [5:0] c, input logic b, input string tag);
        addr = c; we_n = 1'b0; d = b; cas_n = 1'b0; settle();
        chk({tag, " R5 no drive on write"}, {5'd0, q_en}, 6'd0);
        cas_n = 1'b1; settle(); we_n = 1'b1;
    endtask

    task automatic cas_rd(input logic [5:0] c, input logic b, input string tag);
        addr = c; we_n = 1'b1; cas_n = 1'b0; settle();
        chk({tag, " enable"}, {5'd0, q_en}, 6'd1);
        chk({tag, " data"}, {5'd0, q}, {5'd0, b});
        cas_up();
    endtask

    task automatic t_reset();
        chk("R1 q_en", {5'd0, q_en}, 6'd0);
        chk("R1 q", {5'd0, q}, 6'd0);
        chk("R1 rfsh_row", rfsh_row, 6'd0);
        ras_dn(6'd33); cas_rd(6'd17, 1'b0, "R1 cleared cell"); ras_up();
    endtask

    task automatic t_write_read();
        ras_dn(6'd5); cas_wr(6'd3, 1'b1, "R4 write"); ras_up();
        ras_dn(6'd5);
        cas_rd(6'd3, 1'b1, "R4 R3 read back");
        chk("R5 enable off after cas", {5'd0, q_en}, 6'd0);
        chk("R5 q zero when off", {5'd0, q}, 6'd0);
        cas_rd(6'd4, 1'b0, "R3 neighbour column");
        ras_up();
        chk("R5 enable off after ras", {5'd0, q_en}, 6'd0);
        ras_dn(6'd6); cas_rd(6'd3, 1'b0, "R2 other row"); ras_up();
    endtask

    task automatic t_page();
        logic [7:0] pat = 8'hB2;
        ras_dn(6'd10);
        for (int i = 0; i < 8; i++) cas_wr(6'(8 + i), pat[i], "R6 page write");
        for (int i = 7; i >= 0; i--) cas_rd(6'(8 + i), pat[i], "R6 page read same cycle");
        ras_up();
        ras_dn(6'd10);
        for (int i = 0; i < 8; i++) cas_rd(6'(8 + i), pat[i], "R6 R4 page read new cycle");
        ras_up();
    endtask

    task automatic t_latency();
        ras_dn(6'd10);
        addr = 6'd9; we_n = 1'b1; cas_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 enable within 4 cycles", {5'd0, q_en}, 6'd1);
        chk("R9 data within 4 cycles", {5'd0, q}, 6'd1);
        cas_up(); ras_up();
    endtask

    task automatic t_nibble();
        ras_dn(6'd20);
        cas_wr(6'd40, 1'b1, "R7 setup"); cas_wr(6'd41, 1'b0, "R7 setup");
        cas_wr(6'd42, 1'b1, "R7 setup"); cas_wr(6'd43, 1'b1, "R7 setup");
        ras_up();
        nib_mode = 1'b1;
        ras_dn(6'd20);
        cas_rd(6'd42, 1'b1, "R7 nibble first col 42");
        cas_rd(6'd0,  1'b1, "R7 nibble col 43");
        cas_rd(6'd0,  1'b1, "R7 nibble wrap col 40");
        cas_rd(6'd0,  1'b0, "R7 nibble col 41");
        cas_rd(6'd0,  1'b1, "R7 nibble back to col 42");
        ras_up();
        nib_mode = 1'b0;
    endtask

    task automatic cbr_cycle(input string tag);
        cas_n = 1'b0; settle();
        ras_n = 1'b0; settle();
        chk({tag, " R5 R8 no drive in refresh"}, {5'd0, q_en}, 6'd0);
        ras_n = 1'b1; settle();
        cas_n = 1'b1; settle();
    endtask

    task automatic t_refresh();
        cbr_cycle("first");
        chk("R8 pointer step", rfsh_row, 6'd1);
        for (int i = 1; i < 64; i++) cbr_cycle("sweep");
        chk("R8 pointer wrap", rfsh_row, 6'd0);
        ras_dn(6'd5); cas_rd(6'd3, 1'b1, "R8 row 5 kept"); ras_up();
        ras_dn(6'd10); cas_rd(6'd15, 1'b1, "R8 row 10 kept"); cas_rd(6'd14, 1'b0, "R8 row 10 kept");
        ras_up();
        ras_dn(6'd20); cas_rd(6'd41, 1'b0, "R8 row 20 kept"); cas_rd(6'd40, 1'b1, "R8 row 20 kept");
        ras_up();
        chk("R8 pointer unchanged by normal cycles", rfsh_row, 6'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; addr = '0; ras_n = 1'b1; cas_n = 1'b1;
        we_n = 1'b1; d = 1'b0; nib_mode = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_write_read();
        t_page();
        t_latency();
        t_nibble();
        t_refresh();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule